// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block turns the digital output of an analog comparator into an interrupt request. The comparator bit first passes through a chain of synchronizing flops. A small monitor state machine then looks for a rising edge, a falling edge or either edge, depending on a programmable select field. When it sees the selected edge it sets a sticky flag. The flag raises the interrupt line only when the local interrupt enable and the global interrupt enable are both high. Software clears the flag by writing a one to it. Acknowledging the interrupt also clears it.

The comparator's negative input can come from a dedicated pin or from an input multiplexer that it shares with a sibling converter. While the converter's enable is high, two things happen. The comparator monitor is held inactive, and the multiplexer is taken away from the comparator. When the converter is switched off, the comparator gets the multiplexer back. It then waits one arming cycle before it looks for edges again. The same arming cycle follows a software re-enable.

The monitor has three states:
- `ST_IDLE`: the comparator is off or suppressed.
- `ST_ARM`: one masking cycle that loads the reference level.
- `ST_RUN`: edge detection is live.

Its transitions are:
- `ST_IDLE`→`ST_ARM` when the block becomes active.
- `ST_ARM`→`ST_RUN` while it stays active.
- `ST_ARM`→`ST_IDLE` and `ST_RUN`→`ST_IDLE` when it goes inactive.

Top module: `cmp_edge_irq`

## Requirements
- R1: After reset the flag and `irq` read 0, `mux_grant` is 0 and `mux_addr` is 0. Control register 0 resets to all zeros, so the comparator starts enabled with both-edge select and the interrupt disabled.
- R2: Control register 0 has these fields: bit 7 off (1 disables), bit 5 level (read-only), bit 4 flag, bit 3 interrupt enable, bits 1:0 edge select. With edge select 11, a rising edge of `cmp_in` sets the flag and a falling edge does not.
- R3: With edge select 10, a falling edge sets the flag and a rising edge does not.
- R4: With edge select 00, each rising edge and each falling edge sets the flag.
- R5: Edge select 01 is reserved, and no edge sets the flag while it is selected.
- R6: While the off bit is 1, no edge sets the flag. After the off bit returns to 0, there is one masking cycle (`ST_ARM`). A level change that happened while off therefore sets no flag, and later edges are detected again.
- R7: Writing register 0 with bit 4 set clears the flag. Writing it with bit 4 clear leaves the flag unchanged.
- R8: A high `irq_ack` clears the flag in the next cycle unless a new edge is detected in that same cycle.
- R9: `irq` equals flag AND interrupt enable AND `gie`.
- R10: Register 1 holds the multiplexer fields: bit 6 mux enable, bits 2:0 address. When mux enable is 1 and `adc_en` is 0, `mux_grant` is 1 and `mux_addr` shows the address. Otherwise both are 0, and the dedicated pin is used.
- R11: While `adc_en` is 1, `mux_grant` is 0 and no edge sets the flag. After `adc_en` falls, the block re-arms as in R6 and gets the multiplexer back.
- R12: The comparator level reaches `cmp_level` and register 0 bit 5 after the two synchronizing flops. Writes to bit 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 1 | Raw comparator output |
| adc_en | input | 1 | Sibling converter enable; suppresses the comparator |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write register select (0 control, 1 mux) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Read register select |
| rd_data | output | 8 | Read data, 0 when `rd_en` is low |
| irq | output | 1 | Interrupt request |
| mux_grant | output | 1 | Comparator negative input taken from the shared mux |
| mux_addr | output | 3 | Shared mux address while granted |
| cmp_level | output | 1 | Synchronized comparator level |

## Verification
The bench sets up a stale level on purpose. It changes the comparator input while the block is switched off or suppressed by the converter, and then re-enables the block. A design without the arming cycle would report a phantom edge at that point. It also checks that writing zero to the flag bit leaves the flag set. A design that treats the flag as a plain writable bit would lose a pending interrupt. The reserved edge code and the opposite edge of each single-edge mode are driven to catch decode errors, which would set flags on the wrong transitions. Finally, `gie` and the converter enable are toggled under a pending flag to show that `irq` and multiplexer ownership follow them combinationally.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
    typedef enum logic [1:0] {
        EDGE_BOTH = 2'b00,
        EDGE_RSVD = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_RISE = 2'b11
    } edge_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } mon_state_t;

    localparam int CTL_OFF_BIT  = 7;
    localparam int CTL_LVL_BIT  = 5;
    localparam int CTL_FLAG_BIT = 4;
    localparam int CTL_IE_BIT   = 3;
    localparam int MUX_EN_BIT   = 6;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cmp_edge_fsm.sv
module cmp_edge_fsm
    import cmp_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       level,
    input  edge_sel_t  edge_sel,
    output logic       edge_hit,
    output mon_state_t state_o
);
    mon_state_t st, st_nx;
    logic       prev_lvl;

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (active)  st_nx = ST_ARM;
            ST_ARM:  st_nx = active ? ST_RUN : ST_IDLE;
            ST_RUN:  if (!active) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register and reference level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            prev_lvl <= 1'b0;
        end else begin
            st <= st_nx;
            if (st != ST_IDLE) prev_lvl <= level;
        end
    end

    // outputs
    always_comb begin
        logic rise, fall;
        rise     = level & ~prev_lvl;
        fall     = ~level & prev_lvl;
        edge_hit = 1'b0;
        if (st == ST_RUN && active) begin
            unique case (edge_sel)
                EDGE_BOTH: edge_hit = rise | fall;
                EDGE_FALL: edge_hit = fall;
                EDGE_RISE: edge_hit = rise;
                default:   edge_hit = 1'b0;
            endcase
        end
    end

    assign state_o = st;
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
    import cmp_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_addr,
    input  logic              edge_hit,
    input  logic              irq_ack,
    input  logic              level,
    output logic [DATA_W-1:0] rd_data,
    output logic              off_bit,
    output logic              ie_bit,
    output edge_sel_t         edge_sel,
    output logic              flag,
    output logic              mux_en,
    output logic [SEL_W-1:0]  mux_sel
);
    logic wr_ctl, wr_mux, flag_clr;

    assign wr_ctl   = wr_en && (wr_addr == 1'b0);
    assign wr_mux   = wr_en && (wr_addr == 1'b1);
    assign flag_clr = (wr_ctl && wr_data[CTL_FLAG_BIT]) || irq_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_bit  <= 1'b0;
            ie_bit   <= 1'b0;
            edge_sel <= EDGE_BOTH;
            mux_en   <= 1'b0;
            mux_sel  <= '0;
        end else begin
            if (wr_ctl) begin
                off_bit  <= wr_data[CTL_OFF_BIT];
                ie_bit   <= wr_data[CTL_IE_BIT];
                edge_sel <= edge_sel_t'(wr_data[1:0]);
            end
            if (wr_mux) begin
                mux_en  <= wr_data[MUX_EN_BIT];
                mux_sel <= wr_data[SEL_W-1:0];
            end
        end
    end

    // a new edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (edge_hit) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_addr == 1'b0) begin
                rd_data[CTL_OFF_BIT]  = off_bit;
                rd_data[CTL_LVL_BIT]  = level;
                rd_data[CTL_FLAG_BIT] = flag;
                rd_data[CTL_IE_BIT]   = ie_bit;
                rd_data[1:0]          = edge_sel;
            end else begin
                rd_data[MUX_EN_BIT]   = mux_en;
                rd_data[SEL_W-1:0]    = mux_sel;
            end
        end
    end
endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq
    import cmp_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int SEL_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_in,
    input  logic              adc_en,
    input  logic              gie,
    input  logic              irq_ack,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              mux_grant,
    output logic [SEL_W-1:0]  mux_addr,
    output logic              cmp_level
);
    logic             level, active, edge_hit, flag;
    logic             off_bit, ie_bit, mux_en;
    logic [SEL_W-1:0] mux_sel;
    edge_sel_t        edge_sel;
    mon_state_t       mon_st;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cmp_in), .dout(level)
    );

    cmp_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .edge_hit(edge_hit), .irq_ack(irq_ack), .level(level),
        .rd_data(rd_data), .off_bit(off_bit), .ie_bit(ie_bit),
        .edge_sel(edge_sel), .flag(flag), .mux_en(mux_en), .mux_sel(mux_sel)
    );

    assign active = !off_bit && !adc_en;

    cmp_edge_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .level(level),
        .edge_sel(edge_sel), .edge_hit(edge_hit), .state_o(mon_st)
    );

    assign irq       = flag && ie_bit && gie;
    assign mux_grant = mux_en && !adc_en;
    assign mux_addr  = mux_grant ? mux_sel : '0;
    assign cmp_level = level;
endmodule

// File: rtl/cmp_edge_irq_chk.sv
module cmp_edge_irq_chk
    import cmp_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       gie,
    input logic       adc_en,
    input logic       mux_grant,
    input logic       irq_ack,
    input logic       edge_hit,
    input logic       flag,
    input mon_state_t mon_st
);
    a_r9_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie);

    a_r11_adc_takes_mux: assert property (@(posedge clk) disable iff (!rst_n)
        adc_en |-> !mux_grant);

    a_r11_adc_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        adc_en |=> (mon_st == ST_IDLE));

    a_r6_flag_rises_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(mon_st == ST_RUN));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !edge_hit) |=> !flag);
endmodule

bind cmp_edge_irq cmp_edge_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .gie(gie), .adc_en(adc_en),
    .mux_grant(mux_grant), .irq_ack(irq_ack), .edge_hit(edge_hit),
    .flag(flag), .mon_st(mon_st)
);

// File: tb/sim_cmp_edge_irq.sv
`timescale 1ns/1ps
module sim_cmp_edge_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_in = 1'b0, adc_en = 1'b0, gie = 1'b1, irq_ack = 1'b0;
    logic       wr_en = 1'b0, wr_addr = 1'b0, rd_en = 1'b1, rd_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq, mux_grant, cmp_level;
    logic [2:0] mux_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       irq;
        logic       flag;
        logic       lvl;
        logic       grant;
        logic [2:0] addr;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    cmp_edge_irq u0 (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .adc_en(adc_en), .gie(gie),
        .irq_ack(irq_ack), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
        .mux_grant(mux_grant), .mux_addr(mux_addr), .cmp_level(cmp_level)
    );

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                logic [7:0] got;
                e = sb.pop_front();
                got = {irq, rd_data[4], rd_data[5], mux_grant, mux_addr, cmp_level};
                total++;
                if (got !== {e.irq, e.flag, e.lvl, e.grant, e.addr, e.lvl}) begin
                    bad++;
                    $display("FAIL %s: irq/flag/lvl/grant/addr/cmp_level got %b expected %b",
                             e.tag, got, {e.irq, e.flag, e.lvl, e.grant, e.addr, e.lvl});
                end
            end
        end
    end

    task automatic expect_st(input logic i, input logic f, input logic l,
                             input logic g, input logic [2:0] a, input string tag);
        exp_t e;
        e.irq = i; e.flag = f; e.lvl = l; e.grant = g; e.addr = a; e.tag = tag;
        sb.push_back(e);
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic setin(input logic v);
        @(negedge clk);
        cmp_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_st(0, 0, 0, 0, 3'd0, "R1 reset");

        wr(0, 8'h0B);                      // ie, rising
        setin(1);
        expect_st(1, 1, 1, 0, 3'd0, "R2 rise sets flag");
        wr(0, 8'h1B);                      // W1C
        expect_st(0, 0, 1, 0, 3'd0, "R7 write one clears");
        setin(0);
        expect_st(0, 0, 0, 0, 3'd0, "R2 fall ignored");

        wr(0, 8'h0A);                      // falling
        setin(1);
        expect_st(0, 0, 1, 0, 3'd0, "R3 rise ignored");
        setin(0);
        expect_st(1, 1, 0, 0, 3'd0, "R3 fall sets flag");
        wr(0, 8'h0A);
        expect_st(1, 1, 0, 0, 3'd0, "R7 write zero keeps flag");
        ack();
        expect_st(0, 0, 0, 0, 3'd0, "R8 ack clears");

        wr(0, 8'h08);                      // both
        setin(1);
        expect_st(1, 1, 1, 0, 3'd0, "R4 rise");
        ack();
        setin(0);
        expect_st(1, 1, 0, 0, 3'd0, "R4 fall");
        ack();

        wr(0, 8'h09);                      // reserved
        setin(1);
        expect_st(0, 0, 1, 0, 3'd0, "R5 rise");
        setin(0);
        expect_st(0, 0, 0, 0, 3'd0, "R5 fall");

        wr(0, 8'h0B);
        setin(1);
        @(negedge clk); gie = 1'b0;
        expect_st(0, 1, 1, 0, 3'd0, "R9 gie low");
        @(negedge clk); gie = 1'b1;
        expect_st(1, 1, 1, 0, 3'd0, "R9 gie high");
        wr(0, 8'h03);
        expect_st(0, 1, 1, 0, 3'd0, "R9 ie low");
        wr(0, 8'h1B);

        wr(0, 8'h83);                      // off
        setin(0);
        setin(1);
        expect_st(0, 0, 1, 0, 3'd0, "R6 off blocks");
        setin(0);
        wr(0, 8'h08);                      // re-enable, both edges, stale level
        expect_st(0, 0, 0, 0, 3'd0, "R6 arm masks stale");
        setin(1);
        expect_st(1, 1, 1, 0, 3'd0, "R6 resumes");
        wr(0, 8'h18);

        wr(1, 8'h45);
        expect_st(0, 0, 1, 1, 3'd5, "R10 grant");
        wr(1, 8'h05);
        expect_st(0, 0, 1, 0, 3'd0, "R10 pin");

        wr(1, 8'h43);
        @(negedge clk); adc_en = 1'b1;
        setin(0);
        expect_st(0, 0, 0, 0, 3'd0, "R11 adc suppresses");
        @(negedge clk); adc_en = 1'b0;
        repeat (3) @(negedge clk);
        expect_st(0, 0, 0, 1, 3'd3, "R11 release masked");
        setin(1);
        expect_st(1, 1, 1, 1, 3'd3, "R11 resumes");
        wr(0, 8'h18);

        setin(0);
        wr(0, 8'h38);                      // clear, try bit5
        expect_st(0, 0, 0, 1, 3'd3, "R12 level read-only");
        setin(1);
        wr(0, 8'h18);
        expect_st(0, 0, 1, 1, 3'd3, "R12 level follows");

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule